// File: doc/BRIEF.md
# Cascadable Serial Display Loader

This block is the serial front end of a dot-matrix display driver. A host clocks a bit stream into `din` while `ce_n` is held low. The level of `rs` when `ce_n` falls decides where the stream goes: into a 160-bit pixel shift register or into an 8-bit command shift register. When `ce_n` rises, the shifted word is copied into the matching holding register. The serial output `dout` lets any number of drivers share one bus. Each driver passes its stream on to the next one, so pixel data flows through the whole chain.

A command word with its top bit set is the mode word. Its bit 0 picks how `dout` behaves during command loads. Normally `dout` is the last command stage. In broadcast mode, `dout` copies `din` without a register. With broadcast mode, a whole chain takes the same 8-bit command in 8 clocks instead of 8 per device. Bit 1 turns on a divide-by-8 prescaler for the external display oscillator. The block also makes a display-clock tick and a strobe that marks each 512-tick refresh frame. A command word with its top bit clear is stored as a 7-bit general setting.

Top module: `disp_serial_front`

## Requirements
- R1: After reset, all of the following are zero: the mode word, the stored 7-bit setting and the pixel holding register. So `dout_simul`, `prescale_on`, `ctrl0_data`, `dot_data` and `rsv_err` all read 0.
- R2: On each `clk` edge where `ce_n` is low, `din` enters bit 0 of the selected shift register and every other bit moves up one place, so the first bit sent ends in the MSB. The register is chosen by `rs` as sampled in the first low cycle of `ce_n`: 0 selects pixels, 1 selects the command register. Later changes of `rs` during the same load are ignored.
- R3: On the `clk` edge where `ce_n` goes back high after a pixel load, `dot_data` takes the 160-bit shift contents, visible one cycle later. Apart from that edge, `dot_data` never changes.
- R4: In a pixel load, `dout` is the MSB of the pixel shift register, so a bit leaves 160 edges after entry. In a command load in serial mode, `dout` is bit 7 of the command shift register (8 edges of delay).
- R5: While `dout_simul` is 1, `dout` equals `din` combinationally for the whole of a command load (`ce_n` low, `rs` sampled 1).
- R6: Broadcast mode has no effect on pixel loads: `dout` still gives the pixel shift register MSB.
- R7: Latching a command word with bit 7 = 1 sets `dout_simul` from bit 0 and `prescale_on` from bit 1. Latching one with bit 7 = 0 stores bits 6..0 into `ctrl0_data` and leaves both mode bits unchanged.
- R8: Latching a mode word (bit 7 = 1) with any of bits 6..2 set pulses `rsv_err` high for exactly one cycle, in the cycle after the latch edge. Bits 0 and 1 are still applied. A word with bit 7 = 0 never raises `rsv_err`.
- R9: With `osc_ext_sel` = 0 (internal clock), `disp_tick` is high every cycle whatever the value of `prescale_on`.
- R10: With `osc_ext_sel` = 1, `disp_tick` pulses once per rising edge of `osc_ext` after synchronisation. When `prescale_on` = 1, it pulses once per 8 such edges instead.
- R11: `refresh_strobe` is high on every 512th `disp_tick` and only together with a tick, giving one strobe per 512 display ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial shift clock and block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| din | input | 1 | Serial data in |
| ce_n | input | 1 | Active-low load enable; a rising edge latches the word |
| rs | input | 1 | Register select, sampled at the fall of `ce_n` (0 pixels, 1 command) |
| osc_ext | input | 1 | External display oscillator, asynchronous |
| osc_ext_sel | input | 1 | 1 selects the external oscillator, 0 the internal clock |
| dout | output | 1 | Serial output to the next device in the chain |
| dot_data | output | 160 | Latched pixel register |
| ctrl0_data | output | 7 | Stored general setting (command word with bit 7 = 0) |
| dout_simul | output | 1 | Broadcast mode bit of the mode word |
| prescale_on | output | 1 | Divide-by-8 prescaler enable of the mode word |
| rsv_err | output | 1 | One-cycle flag for a mode word with reserved bits set |
| disp_tick | output | 1 | Display-clock enable |
| refresh_strobe | output | 1 | One tick in 512, marks a full refresh |

## Verification
`dout` is combinational on the live shift state. The bench drives each serial bit just after a falling clock edge and compares `dout` a few nanoseconds later in the same low phase. The expected value is the bit entered 160 or 8 edges earlier, or `din` itself in broadcast mode. The holding registers, the mode bits and `rsv_err` settle on the edge where `ce_n` rises, so they are checked at the falling edge that follows. `rsv_err` is checked again one cycle later to confirm it was a single pulse. Display ticks are counted over a window padded for the two-flop synchroniser. The refresh period is measured from one strobe to the next.

// File: rtl/disp_pkg.sv
package disp_pkg;
  localparam int DOT_BITS_DEF  = 160;
  localparam int CTRL_BITS_DEF = 8;
  localparam int PRESCALE_DEF  = 8;
  localparam int REFRESH_DEF   = 512;
  localparam int SYNC_DEF      = 2;

  typedef enum logic {
    SEL_DOT  = 1'b0,
    SEL_CTRL = 1'b1
  } reg_sel_e;

  typedef struct packed {
    logic simul;
    logic prescale;
  } mode_t;
endpackage

// File: rtl/dsr_shift.sv
module dsr_shift #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_en,
  input  logic         din,
  output logic [W-1:0] sr
);
  logic [W-1:0] sr_d;

  always_comb begin
    sr_d = sr;
    if (shift_en) sr_d = {sr[W-2:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr <= '0;
    else        sr <= sr_d;
  end

  // R2: a shifted bit lands in stage 0
  p_shift_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> sr[0] == $past(din));
endmodule

// File: rtl/dsr_ctrl_decode.sv
module dsr_ctrl_decode #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          latch_en,
  input  logic [CW-1:0] word,
  output disp_pkg::mode_t mode,
  output logic [CW-2:0] ctrl0,
  output logic          rsv_err
);
  localparam int RSV_HI = CW - 2;

  disp_pkg::mode_t mode_d;
  logic [CW-2:0]   ctrl0_d;
  logic            err_d;
  logic            is_mode;
  logic            rsv_set;

  assign is_mode = word[CW-1];
  assign rsv_set = |word[RSV_HI:2];

  always_comb begin
    mode_d  = mode;
    ctrl0_d = ctrl0;
    err_d   = 1'b0;
    if (latch_en) begin
      if (is_mode) begin
        mode_d.simul    = word[0];
        mode_d.prescale = word[1];
        err_d           = rsv_set;
      end else begin
        ctrl0_d = word[CW-2:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode    <= '0;
      ctrl0   <= '0;
      rsv_err <= 1'b0;
    end else begin
      mode    <= mode_d;
      ctrl0   <= ctrl0_d;
      rsv_err <= err_d;
    end
  end

  // R7: a general-setting word leaves the mode bits alone
  p_word0_keeps_mode_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_en && !word[CW-1]) |=> $stable(mode));

  // R8: the error flag follows only a mode-word latch
  p_err_after_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsv_err |-> ($past(latch_en) && $past(word[CW-1])));

  // R8: the flag is a single-cycle pulse unless a second latch follows at once
  p_err_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsv_err && !latch_en) |=> !rsv_err);
endmodule

// File: rtl/dsr_dclk_gen.sv
module dsr_dclk_gen #(
  parameter int PRESCALE = 8,
  parameter int REFRESH  = 512,
  parameter int SYNC     = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic osc_ext,
  input  logic ext_sel,
  input  logic prescale,
  output logic disp_tick,
  output logic refresh_strobe
);
  localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam int RW = $clog2(REFRESH);
  localparam logic [PW-1:0] P_LAST = PW'(PRESCALE - 1);
  localparam logic [RW-1:0] R_LAST = RW'(REFRESH - 1);

  logic [SYNC-1:0] sync_q, sync_d;
  logic            prev_q;
  logic            osc_rise;
  logic [PW-1:0]   pcnt_q, pcnt_d;
  logic [RW-1:0]   rcnt_q, rcnt_d;
  logic            use_div;

  generate
    if (SYNC > 1) begin : g_sync_chain
      assign sync_d = {sync_q[SYNC-2:0], osc_ext};
    end else begin : g_sync_single
      assign sync_d = osc_ext;
    end
  endgenerate

  assign osc_rise = sync_q[SYNC-1] & ~prev_q;
  assign use_div  = ext_sel & prescale;

  always_comb begin
    if (!ext_sel)     disp_tick = 1'b1;
    else if (use_div) disp_tick = osc_rise && (pcnt_q == P_LAST);
    else              disp_tick = osc_rise;
  end

  assign refresh_strobe = disp_tick && (rcnt_q == R_LAST);

  always_comb begin
    pcnt_d = pcnt_q;
    if (!use_div)      pcnt_d = '0;
    else if (osc_rise) pcnt_d = (pcnt_q == P_LAST) ? '0 : pcnt_q + 1'b1;
    rcnt_d = rcnt_q;
    if (disp_tick) rcnt_d = (rcnt_q == R_LAST) ? '0 : rcnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
      pcnt_q <= '0;
      rcnt_q <= '0;
    end else begin
      sync_q <= sync_d;
      prev_q <= sync_q[SYNC-1];
      pcnt_q <= pcnt_d;
      rcnt_q <= rcnt_d;
    end
  end

  // R10: divided ticks can never fall in back-to-back cycles
  p_prescale_spacing_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_sel && prescale && disp_tick && $stable(ext_sel) && $stable(prescale))
      |=> !(disp_tick && ext_sel && prescale));

  // R11: a refresh strobe always coincides with a tick
  p_strobe_on_tick_r11: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_strobe |-> disp_tick);
endmodule

// File: rtl/disp_serial_front.sv
module disp_serial_front #(
  parameter int DOT_BITS  = disp_pkg::DOT_BITS_DEF,
  parameter int CTRL_BITS = disp_pkg::CTRL_BITS_DEF,
  parameter int PRESCALE  = disp_pkg::PRESCALE_DEF,
  parameter int REFRESH   = disp_pkg::REFRESH_DEF,
  parameter int SYNC      = disp_pkg::SYNC_DEF
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 din,
  input  logic                 ce_n,
  input  logic                 rs,
  input  logic                 osc_ext,
  input  logic                 osc_ext_sel,
  output logic                 dout,
  output logic [DOT_BITS-1:0]  dot_data,
  output logic [CTRL_BITS-2:0] ctrl0_data,
  output logic                 dout_simul,
  output logic                 prescale_on,
  output logic                 rsv_err,
  output logic                 disp_tick,
  output logic                 refresh_strobe
);
  import disp_pkg::*;

  localparam int DOT_MSB  = DOT_BITS - 1;
  localparam int CTRL_MSB = CTRL_BITS - 1;

  logic [1:0] rst_pipe;
  logic       rst_s_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s_n = rst_pipe[1];

  logic     ce_n_q;
  reg_sel_e sel_q, sel_d, sel_eff;
  logic     ce_fall, ce_rise;
  logic     dot_shift_en, ctrl_shift_en;
  logic     dot_latch_en, ctrl_latch_en;
  logic [DOT_BITS-1:0]  dot_sr;
  logic [DOT_BITS-1:0]  dot_q, dot_d;
  logic [CTRL_BITS-1:0] ctrl_sr;
  mode_t    mode;

  assign ce_fall = ce_n_q & ~ce_n;
  assign ce_rise = ~ce_n_q & ce_n;
  assign sel_eff = ce_fall ? reg_sel_e'(rs) : sel_q;

  assign dot_shift_en  = ~ce_n && (sel_eff == SEL_DOT);
  assign ctrl_shift_en = ~ce_n && (sel_eff == SEL_CTRL);
  assign dot_latch_en  = ce_rise && (sel_q == SEL_DOT);
  assign ctrl_latch_en = ce_rise && (sel_q == SEL_CTRL);

  always_comb begin
    sel_d = sel_q;
    if (ce_fall) sel_d = reg_sel_e'(rs);
    dot_d = dot_q;
    if (dot_latch_en) dot_d = dot_sr;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      ce_n_q <= 1'b1;
      sel_q  <= SEL_DOT;
      dot_q  <= '0;
    end else begin
      ce_n_q <= ce_n;
      sel_q  <= sel_d;
      dot_q  <= dot_d;
    end
  end

  dsr_shift #(.W(DOT_BITS)) u_dot_shift (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .shift_en (dot_shift_en),
    .din      (din),
    .sr       (dot_sr)
  );

  dsr_shift #(.W(CTRL_BITS)) u_ctrl_shift (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .shift_en (ctrl_shift_en),
    .din      (din),
    .sr       (ctrl_sr)
  );

  dsr_ctrl_decode #(.CW(CTRL_BITS)) u_decode (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .latch_en (ctrl_latch_en),
    .word     (ctrl_sr),
    .mode     (mode),
    .ctrl0    (ctrl0_data),
    .rsv_err  (rsv_err)
  );

  dsr_dclk_gen #(.PRESCALE(PRESCALE), .REFRESH(REFRESH), .SYNC(SYNC)) u_dclk (
    .clk            (clk),
    .rst_n          (rst_s_n),
    .osc_ext        (osc_ext),
    .ext_sel        (osc_ext_sel),
    .prescale       (mode.prescale),
    .disp_tick      (disp_tick),
    .refresh_strobe (refresh_strobe)
  );

  always_comb begin
    if (sel_eff == SEL_DOT)     dout = dot_sr[DOT_MSB];
    else if (mode.simul && !ce_n) dout = din;
    else                        dout = ctrl_sr[CTRL_MSB];
  end

  assign dot_data    = dot_q;
  assign dout_simul  = mode.simul;
  assign prescale_on = mode.prescale;

  // R3: the pixel latch moves only on the edge that ends a load
  p_dot_hold_r3: assert property (@(posedge clk) disable iff (!rst_s_n)
    $past(ce_n_q) |-> $stable(dot_data));

  // R2: the select register cannot change in the middle of a load
  p_sel_stable_r2: assert property (@(posedge clk) disable iff (!rst_s_n)
    (!ce_n && !ce_n_q) |=> $stable(sel_q));
endmodule

// File: tb/tb_disp_serial_front.sv
module tb_disp_serial_front;
  localparam int CLK_PERIOD = 10;
  localparam int DOTS = 160;

  logic clk = 1'b0;
  logic rst_n, din, ce_n, rs, osc_ext, osc_ext_sel;
  logic dout, dout_simul, prescale_on, rsv_err, disp_tick, refresh_strobe;
  logic [DOTS-1:0] dot_data;
  logic [6:0] ctrl0_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  disp_serial_front dut (
    .clk(clk), .rst_n(rst_n), .din(din), .ce_n(ce_n), .rs(rs),
    .osc_ext(osc_ext), .osc_ext_sel(osc_ext_sel), .dout(dout),
    .dot_data(dot_data), .ctrl0_data(ctrl0_data), .dout_simul(dout_simul),
    .prescale_on(prescale_on), .rsv_err(rsv_err), .disp_tick(disp_tick),
    .refresh_strobe(refresh_strobe)
  );

  typedef struct {
    string       tag;
    int          sig;
    logic [31:0] exp;
  } item_t;

  item_t sb_q[$];
  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  logic [DOTS-1:0] dot_prev;
  logic [7:0]      ctrl_prev;
  bit              sim_model;

  function automatic logic [31:0] probe(int sig);
    case (sig)
      0: return {31'd0, dout};
      1: return {31'd0, dout_simul};
      2: return {31'd0, prescale_on};
      3: return {25'd0, ctrl0_data};
      default: return {31'd0, rsv_err};
    endcase
  endfunction

  task automatic expect_q(input string tag, input int sig, input logic [31:0] exp);
    item_t it;
    it.tag = tag; it.sig = sig; it.exp = exp;
    sb_q.push_back(it);
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // monitor: pops scoreboard items in the low phase after the driver set inputs
  initial begin
    forever begin
      @(negedge clk);
      #3;
      while (sb_q.size() > 0) begin
        item_t it;
        it = sb_q.pop_front();
        check(it.tag, probe(it.sig), it.exp);
      end
    end
  end

  task automatic dot_write(input logic [DOTS-1:0] pat, input bit wiggle_rs, input string tag);
    for (int k = 0; k < DOTS; k++) begin
      @(negedge clk);
      ce_n = 1'b0;
      rs   = (wiggle_rs && k > 0) ? 1'b1 : 1'b0;
      din  = pat[DOTS-1-k];
      expect_q(tag, 0, {31'd0, dot_prev[DOTS-1-k]});
    end
    @(negedge clk);
    ce_n = 1'b1; din = 1'b0; rs = 1'b0;
    @(negedge clk);
    check({tag, " latch R3"}, {31'd0, dot_data == pat}, 32'd1);
    dot_prev = pat;
  endtask

  task automatic ctrl_write(input logic [7:0] w, input string tag);
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      ce_n = 1'b0; rs = 1'b1;
      din  = w[7-k];
      if (sim_model) expect_q({tag, " dout R5"}, 0, {31'd0, w[7-k]});
      else           expect_q({tag, " dout R4"}, 0, {31'd0, ctrl_prev[7-k]});
    end
    @(negedge clk);
    ce_n = 1'b1; din = 1'b0; rs = 1'b0;
    ctrl_prev = w;
    if (w[7]) sim_model = w[0];
  endtask

  int cnt;
  logic [6:0] c0_model;
  bit pre_model;

  initial begin
    rst_n = 1'b0; din = 1'b0; ce_n = 1'b1; rs = 1'b0;
    osc_ext = 1'b0; osc_ext_sel = 1'b0;
    dot_prev = '0; ctrl_prev = '0; sim_model = 0; c0_model = '0; pre_model = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check("R1 simul", {31'd0, dout_simul}, 0);
    check("R1 prescale", {31'd0, prescale_on}, 0);
    check("R1 ctrl0", {25'd0, ctrl0_data}, 0);
    check("R1 dot", {31'd0, dot_data == '0}, 1);
    check("R1 err", {31'd0, rsv_err}, 0);

    // R2/R3/R4 pixel load, then a second load streaming the first out
    dot_write({5{32'hA5C3_0F96}}, 1'b0, "R4 dot A");
    dot_write({5{32'h1234_FEDC}}, 1'b1, "R2 rs ignored, R4 dot B");
    check("R2 mid-load rs: ctrl0 untouched", {25'd0, ctrl0_data}, 0);

    // R4 serial command load, R7 mode word
    ctrl_write(8'h82, "R4 ctrl 82");
    @(negedge clk);
    expect_q("R7 simul after 82", 1, 0);
    expect_q("R7 prescale after 82", 2, 1);
    ctrl_write(8'h81, "R4 ctrl 81");
    @(negedge clk);
    expect_q("R7 simul after 81", 1, 1);
    expect_q("R7 prescale after 81", 2, 0);

    // R5 broadcast command load
    ctrl_write(8'h81, "R5 ctrl 81 sim");
    @(negedge clk);

    // R6 pixel load while broadcasting
    dot_write({5{32'h0F0F_3C3C}}, 1'b0, "R6 dot C sim");

    // R8 reserved bits in a mode word
    ctrl_write(8'hA1, "R8 ctrl A1");
    @(negedge clk);
    expect_q("R8 err pulse", 4, 1);
    expect_q("R8 simul still applied", 1, 1);
    @(negedge clk);
    expect_q("R8 err single cycle", 4, 0);

    // R7/R8 general-setting word with high bits: stored, no flag, mode kept
    ctrl_write(8'h7D, "R7 ctrl 7D");
    @(negedge clk);
    expect_q("R7 ctrl0 stored", 3, 32'h7D);
    expect_q("R8 no err for word0", 4, 0);
    expect_q("R7 simul kept", 1, 1);
    expect_q("R7 prescale kept", 2, 0);

    // R9 internal clock: tick every cycle even with prescale on
    ctrl_write(8'h83, "R5 ctrl 83");
    @(negedge clk);
    expect_q("R7 prescale set", 2, 1);
    cnt = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk); #3;
      if (disp_tick) cnt++;
    end
    check("R9 internal ticks", cnt, 40);

    // R11 refresh period in internal mode
    cnt = 0;
    while (!refresh_strobe && cnt < 700) begin @(negedge clk); #3; cnt++; end
    cnt = 0;
    do begin @(negedge clk); #3; cnt++; end while (!refresh_strobe && cnt < 700);
    check("R11 refresh period", cnt, 512);

    // R10 external, prescale off
    ctrl_write(8'h81, "R5 ctrl 81");
    @(negedge clk);
    osc_ext_sel = 1'b1;
    repeat (6) @(negedge clk);
    cnt = 0;
    for (int i = 0; i < 64 * 4 + 8; i++) begin
      @(negedge clk);
      osc_ext = (i < 64 * 4) ? ((i % 4) < 2) : 1'b0;
      #3;
      if (disp_tick) cnt++;
    end
    check("R10 ext ticks undivided", cnt, 64);

    // R10 external, prescale on
    ctrl_write(8'h83, "R5 ctrl 83");
    @(negedge clk);
    cnt = 0;
    for (int i = 0; i < 64 * 4 + 8; i++) begin
      @(negedge clk);
      osc_ext = (i < 64 * 4) ? ((i % 4) < 2) : 1'b0;
      #3;
      if (disp_tick) cnt++;
    end
    check("R10 ext ticks divided", cnt, 8);
    osc_ext_sel = 1'b0;

    // R1 second reset clears everything set above
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 re-reset simul", {31'd0, dout_simul}, 0);
    check("R1 re-reset prescale", {31'd0, prescale_on}, 0);
    check("R1 re-reset ctrl0", {25'd0, ctrl0_data}, 0);
    check("R1 re-reset dot", {31'd0, dot_data == '0}, 1);

    repeat (2) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      done = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule